// File: doc/BRIEF.md
# Double-Pumped Read Return Receiver

This block sits on the bus-master side of a 32-bit graphics port. It takes read-return data off the shared address/data bus and turns it into 64-bit quadwords in the base-clock domain. In the double-rate mode, each half of the bus has its own source strobe. Each strobe latches its 16-bit half on both of its edges: the falling edge latches the first word of a base-clock period and the rising edge latches the second. The captured halves wait in a small two-pair buffer. They are combined into a quadword only once both halves have delivered a full pair and the active-low target-ready input says the data may be used.

In the single-rate mode no strobes are used. On each base clock where target-ready is low, the bus is sampled once, and two consecutive words are packed into one quadword. In both modes a 3-bit status code tags the read data as low or high priority. A code that is neither of these sets a sticky error and the data is thrown away. Returns are grouped into transactions of a programmed length of one to four quadwords. The final quadword of each transaction carries a last flag.

Top module: `dpump_rd_rx`

## Requirements
- R1: A synchronous active-low reset clears q_valid, q_last, q_hi and proto_err, and it empties the strobe capture buffer and the held single-rate word. After reset, a clock with target-ready low and no new strobe edges produces no output.
- R2: In double-rate mode (mode_1x=0), strb[0] captures ad[15:0] and strb[1] captures ad[31:16], each on both of its edges. The falling edge gives the first word and the rising edge the second. The quadword is {second word, first word}, so the first word sits in bits 31:0. It is released only after both halves have delivered their pair, and it appears with q_valid one clock after the base-clock edge that takes it.
- R3: While trdy_n is high, no quadword is released. Up to two captured pairs are held and later released in arrival order, one per clock with trdy_n low.
- R4: In single-rate mode (mode_1x=1), ad is sampled at each clock edge where trdy_n is low. Two consecutive sampled words form one quadword, with the earlier word in bits 31:0. Words on clocks with trdy_n high are ignored.
- R5: Status 3'b000 marks low-priority data and 3'b001 marks high-priority data. q_hi carries the tag of the transaction's first quadword and holds it for every quadword of that transaction.
- R6: qlen holds the length minus one, so 0 to 3 means 1 to 4 quadwords. It is sampled at the clock that produces a transaction's first quadword. q_last is high with, and only with, that transaction's final quadword.
- R7: In double-rate mode, back-to-back one-quadword transactions are accepted on consecutive clocks with trdy_n low every clock. The status code may repeat the same value or change between them.
- R8: A status code other than 000 or 001 at a clock that takes data sets proto_err, which stays set until reset. The taken data is dropped and does not advance the transaction count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_1x | input | 1 | 1 selects single-rate sampling, 0 selects double-rate strobe capture |
| ad | input | 32 | Shared address/data bus |
| strb | input | 2 | Source strobes, bit h for bus half h, idle high |
| trdy_n | input | 1 | Active-low target-ready, allows data to be consumed |
| st | input | 3 | Status code, 000 low priority, 001 high priority |
| qlen | input | LEN_W | Transaction length in quadwords minus one |
| q_valid | output | 1 | Quadword valid pulse |
| q_data | output | 64 | Completed quadword |
| q_last | output | 1 | Final quadword of a transaction |
| q_hi | output | 1 | Priority tag of the transaction |
| proto_err | output | 1 | Sticky bad-status flag |

## Verification
If the buffer read pointer drifts from the strobe write pointers, the fault shows up one clock after the next qualified edge. It appears either as a quadword released before both halves have arrived, or as data from the wrong pair, most visibly when one half's strobe is late or when two pairs are held behind trdy_n high. A beat counter or stored length that is off shows up as a misplaced q_last at the end of the very next transaction. A priority tag latched at the wrong beat shows up as q_hi changing partway through a multi-quadword transaction. A held single-rate word that is lost or not cleared shows up as swapped or merged halves in the next quadword.

// File: rtl/dpump_rd_rx.sv
module dpump_rd_rx #(
  parameter int LEN_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_1x,
  input  logic [31:0]      ad,
  input  logic [1:0]       strb,
  input  logic             trdy_n,
  input  logic [2:0]       st,
  input  logic [LEN_W-1:0] qlen,
  output logic             q_valid,
  output logic [63:0]      q_data,
  output logic             q_last,
  output logic             q_hi,
  output logic             proto_err
);

  logic [31:0] f_word, r_word;
  logic [3:0]  f_ptrs, r_ptrs;
  logic [1:0]  rp;

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [15:0] fb [2];
    logic [15:0] rb [2];
    logic [1:0]  fp, rpw;

    always_ff @(negedge strb[h]) begin
      if (!rst_n) fp <= '0;
      else begin
        fb[fp[0]] <= ad[16*h +: 16];
        fp <= fp + 2'd1;
      end
    end

    always_ff @(posedge strb[h]) begin
      if (!rst_n) rpw <= '0;
      else begin
        rb[rpw[0]] <= ad[16*h +: 16];
        rpw <= rpw + 2'd1;
      end
    end

    assign f_word[16*h +: 16] = fb[rp[0]];
    assign r_word[16*h +: 16] = rb[rp[0]];
    assign f_ptrs[2*h +: 2]   = fp;
    assign r_ptrs[2*h +: 2]   = rpw;
  end

  wire pair_rdy = (f_ptrs[1:0] != rp) && (f_ptrs[3:2] != rp) &&
                  (r_ptrs[1:0] != rp) && (r_ptrs[3:2] != rp);
  wire sts_ok   = (st == 3'b000) || (st == 3'b001);
  wire take2x   = !mode_1x && !trdy_n && pair_rdy;
  wire take1x   = mode_1x && !trdy_n;
  wire bad      = (take2x || take1x) && !sts_ok;

  logic             held_v, held_hi, tag_l;
  logic [31:0]      held_w;
  logic [LEN_W-1:0] beat, len_l;

  wire             emit    = sts_ok && (take2x || (take1x && held_v));
  wire [63:0]      next_q  = mode_1x ? {ad, held_w} : {r_word, f_word};
  wire             word_hi = mode_1x ? held_hi : st[0];
  wire [LEN_W-1:0] cur_len = (beat == '0) ? qlen : len_l;
  wire             fin     = (beat == cur_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp        <= f_ptrs[1:0];
      held_v    <= 1'b0;
      held_hi   <= 1'b0;
      held_w    <= '0;
      beat      <= '0;
      len_l     <= '0;
      tag_l     <= 1'b0;
      q_valid   <= 1'b0;
      q_last    <= 1'b0;
      q_hi      <= 1'b0;
      q_data    <= '0;
      proto_err <= 1'b0;
    end else begin
      q_valid <= emit;
      q_last  <= emit && fin;
      if (take2x) rp <= rp + 2'd1;
      if (bad) proto_err <= 1'b1;
      if (take1x && sts_ok) begin
        if (held_v) held_v <= 1'b0;
        else begin
          held_v  <= 1'b1;
          held_w  <= ad;
          held_hi <= st[0];
        end
      end
      if (emit) begin
        q_data <= next_q;
        q_hi   <= (beat == '0) ? word_hi : tag_l;
        if (beat == '0) begin
          len_l <= qlen;
          tag_l <= word_hi;
        end
        beat <= fin ? '0 : beat + 1'b1;
      end
    end
  end

  wire [1:0] fill0 = f_ptrs[1:0] - rp;

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trdy_n |=> !q_valid);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill0 != 2'd3);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  assert_bad_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> (proto_err && !q_valid));

  assert_last_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    q_last |-> q_valid);

endmodule

// File: tb/tb_dpump_rd_rx.sv
module tb_dpump_rd_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_1x = 1'b0;
  logic [31:0] ad = '0;
  logic [1:0]  strb = 2'b11;
  logic        trdy_n = 1'b1;
  logic [2:0]  st = 3'b000;
  logic [1:0]  qlen = 2'd0;
  logic        q_valid, q_last, q_hi, proto_err;
  logic [63:0] q_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic        s_v, s_l, s_h, s_e;
  logic [63:0] s_d;

  dpump_rd_rx dut (.clk, .rst_n, .mode_1x, .ad, .strb, .trdy_n, .st, .qlen,
                   .q_valid, .q_data, .q_last, .q_hi, .proto_err);

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // one base-clock period: drives take effect at the next edge,
  // the sample taken here shows the result of the edge that opened it
  task automatic cyc(input logic [1:0] m, input logic [31:0] a, input logic [31:0] b,
                     input logic tr, input logic [2:0] s);
    @(posedge clk);
    #1 trdy_n = tr; st = s; ad = a;
    #4 strb = strb & ~m;
    #3 ad = b;
    #2 s_v = q_valid; s_d = q_data; s_l = q_last; s_h = q_hi; s_e = proto_err;
    #5 strb = strb | m;
  endtask

  task automatic do_reset();
    @(posedge clk);
    #1 rst_n = 1'b0; trdy_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    cyc(2'b11, 32'h0, 32'h0, 1'b1, 3'b000);
    cyc(2'b11, 32'h0, 32'h0, 1'b1, 3'b000);
    do_reset();
    cyc(2'b00, 32'h0, 32'h0, 1'b0, 3'b000);
    cyc(2'b00, 32'h0, 32'h0, 1'b1, 3'b000);
    chk("R1 valid after reset", {63'd0, s_v}, 64'd0);
    chk("R1 last after reset", {63'd0, s_l}, 64'd0);
    chk("R1 err after reset", {63'd0, s_e}, 64'd0);
  endtask

  task automatic t_single();
    qlen = 2'd0;
    cyc(2'b11, 32'h1111_2222, 32'h3333_4444, 1'b0, 3'b000);
    cyc(2'b00, 32'h0, 32'h0, 1'b1, 3'b000);
    chk("R2 valid", {63'd0, s_v}, 64'd1);
    chk("R2 data order", s_d, 64'h3333_4444_1111_2222);
    chk("R6 single last", {63'd0, s_l}, 64'd1);
    chk("R5 low tag", {63'd0, s_h}, 64'd0);
  endtask

  task automatic t_skew();
    qlen = 2'd0;
    cyc(2'b01, 32'hAAAA_0001, 32'hBBBB_0002, 1'b0, 3'b000);
    cyc(2'b10, 32'h00C3_9999, 32'h00D4_8888, 1'b0, 3'b000);
    chk("R2 no release with one half", {63'd0, s_v}, 64'd0);
    cyc(2'b00, 32'h0, 32'h0, 1'b1, 3'b000);
    chk("R2 skewed valid", {63'd0, s_v}, 64'd1);
    chk("R2 skewed halves", s_d, 64'h00D4_0002_00C3_0001);
  endtask

  task automatic t_hold();
    qlen = 2'd1;
    cyc(2'b11, 32'h5000_0001, 32'h5000_0002, 1'b1, 3'b000);
    cyc(2'b11, 32'h6000_0001, 32'h6000_0002, 1'b1, 3'b000);
    chk("R3 held not released", {63'd0, s_v}, 64'd0);
    cyc(2'b00, 32'h0, 32'h0, 1'b0, 3'b000);
    chk("R3 still held", {63'd0, s_v}, 64'd0);
    cyc(2'b00, 32'h0, 32'h0, 1'b0, 3'b000);
    chk("R3 first pair out", s_d, 64'h5000_0002_5000_0001);
    chk("R6 first of two not last", {63'd0, s_l}, 64'd0);
    cyc(2'b00, 32'h0, 32'h0, 1'b1, 3'b000);
    chk("R3 second pair out", s_d, 64'h6000_0002_6000_0001);
    chk("R6 second of two last", {63'd0, s_l}, 64'd1);
    cyc(2'b00, 32'h0, 32'h0, 1'b1, 3'b000);
    chk("R3 buffer drained", {63'd0, s_v}, 64'd0);
  endtask

  task automatic t_b2b();
    qlen = 2'd0;
    cyc(2'b11, 32'hA0, 32'hA1, 1'b0, 3'b000);
    cyc(2'b11, 32'hB0, 32'hB1, 1'b0, 3'b001);
    chk("R7 beat A", s_d, {32'hA1, 32'hA0});
    chk("R5 beat A tag", {63'd0, s_h}, 64'd0);
    cyc(2'b11, 32'hC0, 32'hC1, 1'b0, 3'b001);
    chk("R7 beat B", s_d, {32'hB1, 32'hB0});
    chk("R5 beat B tag", {63'd0, s_h}, 64'd1);
    cyc(2'b11, 32'hD0, 32'hD1, 1'b0, 3'b000);
    chk("R7 beat C valid", {63'd0, s_v}, 64'd1);
    chk("R7 beat C repeated tag", {63'd0, s_h}, 64'd1);
    cyc(2'b00, 32'h0, 32'h0, 1'b1, 3'b000);
    chk("R7 beat D", s_d, {32'hD1, 32'hD0});
    chk("R7 beat D last", {63'd0, s_l}, 64'd1);
    chk("R5 beat D tag", {63'd0, s_h}, 64'd0);
  endtask

  task automatic t_len4();
    qlen = 2'd3;
    cyc(2'b11, 32'h10, 32'h11, 1'b0, 3'b001);
    for (int i = 1; i < 5; i++) begin
      if (i < 4) cyc(2'b11, 32'h10 + 2*i, 32'h11 + 2*i, 1'b0, 3'b000);
      else       cyc(2'b00, 32'h0, 32'h0, 1'b1, 3'b000);
      chk("R6 len4 valid", {63'd0, s_v}, 64'd1);
      chk("R6 len4 last", {63'd0, s_l}, {63'd0, i == 4});
      chk("R5 len4 held tag", {63'd0, s_h}, 64'd1);
    end
  endtask

  task automatic t_1x();
    mode_1x = 1'b1;
    qlen = 2'd1;
    cyc(2'b00, 32'hC001, 32'hC001, 1'b0, 3'b000);
    cyc(2'b00, 32'hC002, 32'hC002, 1'b0, 3'b000);
    chk("R4 first word held", {63'd0, s_v}, 64'd0);
    cyc(2'b00, 32'hDEAD, 32'hDEAD, 1'b1, 3'b000);
    chk("R4 packed pair", s_d, {32'hC002, 32'hC001});
    chk("R6 1x not last", {63'd0, s_l}, 64'd0);
    cyc(2'b00, 32'hC003, 32'hC003, 1'b0, 3'b000);
    chk("R4 ignored word", {63'd0, s_v}, 64'd0);
    cyc(2'b00, 32'hC004, 32'hC004, 1'b0, 3'b000);
    chk("R4 third word held", {63'd0, s_v}, 64'd0);
    cyc(2'b00, 32'h0, 32'h0, 1'b1, 3'b000);
    chk("R4 second pair skips ignored", s_d, {32'hC004, 32'hC003});
    chk("R6 1x last", {63'd0, s_l}, 64'd1);
    mode_1x = 1'b0;
  endtask

  task automatic t_bad();
    qlen = 2'd0;
    cyc(2'b11, 32'hEE0, 32'hEE1, 1'b0, 3'b010);
    cyc(2'b11, 32'hF0, 32'hF1, 1'b0, 3'b000);
    chk("R8 bad dropped", {63'd0, s_v}, 64'd0);
    chk("R8 err set", {63'd0, s_e}, 64'd1);
    cyc(2'b11, 32'h0, 32'h0, 1'b1, 3'b000);
    chk("R8 next good pair", s_d, {32'hF1, 32'hF0});
    chk("R8 count not advanced", {63'd0, s_l}, 64'd1);
    chk("R8 err sticky", {63'd0, s_e}, 64'd1);
    cyc(2'b00, 32'h0, 32'h0, 1'b1, 3'b000);
    do_reset();
    cyc(2'b00, 32'h0, 32'h0, 1'b0, 3'b000);
    cyc(2'b00, 32'h0, 32'h0, 1'b1, 3'b000);
    chk("R1 held pair flushed by reset", {63'd0, s_v}, 64'd0);
    chk("R1 err cleared by reset", {63'd0, s_e}, 64'd0);
  endtask

  initial begin
    t_reset();
    t_single();
    t_skew();
    t_hold();
    t_b2b();
    t_len4();
    t_1x();
    t_bad();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule